// File: doc/BRIEF.md
# Prioritized EDCA Backoff Controller

This block is the channel-access engine for one access category of a wireless station. It waits for an arbitration interval of idle slots and then counts down a random backoff drawn from a 16-bit LFSR. The count freezes while the medium is busy. When the count runs out on an idle slot, the block pulses a transmit-start output. The transmit result then updates the contention window. A success shrinks the window back to its minimum. A failure doubles it, up to a configurable ceiling.

A failed attempt also makes the station eligible for prioritized access. While eligible, the engine sends a one-slot defer pulse at the start of every contention period. That pulse silences stations that do not send it, so only the signalling stations contend in the period that follows. Several eligible stations may send the pulse in the same slot; the engine does not treat this as a collision.

A station that is not signalling but hears a defer pulse locks out for the rest of that period, and its backoff counter stays frozen. The same happens to an eligible station that hears a pulse coded for a different BSS. The engine returns to plain contention after a success, or after the retry limit discards the frame.

Top module: `edca_prio_ctrl`

## Requirements
- R1: While reset is held, `tx_start_o` and `ds_tx_o` are low, `cw_o` equals the minimum window 15 and `prio_o` is low.
- R2: Backoff begins only after AIFSN (default 2) consecutive idle slot ticks. A slot tick with `busy_i` high during that interval restarts the idle count from zero.
- R3: Each new attempt loads the backoff counter with the current LFSR value ANDed with `cw_o`, after which the LFSR takes one step. The LFSR shifts left with new bit0 = q15^q13^q12^q10 and resets to 0xACE1. The counter falls by one on each idle tick. `tx_start_o` rises on the idle tick where the counter is zero, so in a clean period it fires on idle tick AIFSN+value+1. All outputs are registered: a pulse is high for exactly the one clock after the sampled tick.
- R4: A busy tick during backoff freezes the counter. Counting resumes with the remaining value only after a full AIFSN of idle ticks.
- R5: A failed result sets the window to min((cw+1)*2-1, CW_MAX) and raises `prio_o`. The bench uses CW_MAX = 63, so the window goes 15, 31, 63, 63.
- R6: While `prio_o` is high, the first idle tick of every contention period produces a `ds_tx_o` pulse. A period starts at a new attempt or after any busy tick. That tick does not count toward AIFSN, so a clean prioritized attempt transmits on idle tick AIFSN+value+2. `ds_tx_o` never fires while `prio_o` is low.
- R7: A defer pulse detected in the engine's own signalling tick with `ds_match_i` high has no effect: the attempt proceeds as if nothing had been detected.
- R8: A defer pulse detected in the engine's own signalling tick with `ds_match_i` low locks the engine out. It makes no transmission until a busy tick, after which a new period starts with the backoff value unchanged.
- R9: An engine that is not signalling and sees `ds_det_i` on an idle tick locks out with its counter frozen. After the next busy tick it resumes with a full AIFSN.
- R10: A successful result sets `cw_o` to 15 and clears `prio_o`. The engine then waits idle for a new `pending_i` request.
- R11: The seventh consecutive failure discards the frame: `cw_o` returns to 15, `prio_o` clears, and no transmission follows until a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_tick_i | input | 1 | One-cycle pulse marking each slot boundary |
| busy_i | input | 1 | Medium busy for the slot, sampled on the tick |
| ds_det_i | input | 1 | A defer pulse was heard in this slot, sampled on the tick |
| ds_match_i | input | 1 | The heard defer pulse carries this station's BSS code |
| pending_i | input | 1 | A frame is waiting; sampled while the engine is idle |
| tx_done_i | input | 1 | One-cycle strobe reporting the outcome of the transmission |
| tx_ok_i | input | 1 | Outcome qualifier: 1 success, 0 failure |
| tx_start_o | output | 1 | One-cycle pulse: begin the frame transmission |
| ds_tx_o | output | 1 | One-cycle pulse: send the defer signal in this slot |
| cw_o | output | $clog2(CW_MAX+1) | Current contention window |
| prio_o | output | 1 | Eligible for prioritized access |

## Verification
The hardest condition to reach is an eligible engine that hears a foreign-BSS pulse in the very slot where it sends its own. The stimulus builds a failure history first, so that eligibility is set and the window has grown. The next attempt then opens with a tick carrying detect high and match low. The bench shows the lockout by running more idle ticks than the drawn backoff needs and seeing no transmit pulse. A busy tick follows, then a fresh period, and the bench confirms that the defer pulse and the transmit slot land where the unchanged backoff value predicts. Every drawn value comes from a bench model of the LFSR polynomial stated in R3, so each transmit slot is known exactly.

// File: rtl/edca_prio_pkg.sv
package edca_prio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAW,
    ST_AIFS,
    ST_BACKOFF,
    ST_LOCK,
    ST_WAIT
  } edca_st_e;
endpackage

// File: rtl/edca_lfsr.sv
module edca_lfsr #(
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter int          OUT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [OUT_W-1:0] value_o
);
  logic [15:0] q;
  logic        fb;

  assign fb      = q[15] ^ q[13] ^ q[12] ^ q[10];
  assign value_o = q[OUT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (step_i) q <= {q[14:0], fb};
  end
endmodule

// File: rtl/edca_cw_ctrl.sv
module edca_cw_ctrl #(
  parameter int CW_MIN      = 15,
  parameter int CW_MAX      = 1023,
  parameter int RETRY_LIMIT = 7,
  parameter int CW_W        = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            done_i,
  input  logic            ok_i,
  output logic [CW_W-1:0] cw_o,
  output logic            elig_o,
  output logic            last_o
);
  localparam int            RT_W    = $clog2(RETRY_LIMIT + 1);
  localparam logic [CW_W:0] CW_CAP  = (CW_W+1)'(CW_MAX);
  localparam logic [RT_W-1:0] RT_LAST = RT_W'(RETRY_LIMIT - 1);

  logic [CW_W-1:0] cw_q;
  logic [RT_W-1:0] retry_q;
  logic            elig_q;
  logic [CW_W:0]   cw_dbl;
  logic [CW_W-1:0] cw_grow;

  assign cw_dbl  = {cw_q, 1'b1};
  assign cw_grow = (cw_dbl > CW_CAP) ? CW_CAP[CW_W-1:0] : cw_dbl[CW_W-1:0];
  assign last_o  = (retry_q == RT_LAST);
  assign cw_o    = cw_q;
  assign elig_o  = elig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cw_q    <= CW_W'(CW_MIN);
      retry_q <= '0;
      elig_q  <= 1'b0;
    end else if (done_i) begin
      if (ok_i || last_o) begin
        cw_q    <= CW_W'(CW_MIN);
        retry_q <= '0;
        elig_q  <= 1'b0;
      end else begin
        cw_q    <= cw_grow;
        retry_q <= retry_q + 1'b1;
        elig_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/edca_prio_ctrl.sv
module edca_prio_ctrl
  import edca_prio_pkg::*;
#(
  parameter int          AIFSN       = 2,
  parameter int          CW_MIN      = 15,
  parameter int          CW_MAX      = 1023,
  parameter int          RETRY_LIMIT = 7,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1,
  localparam int         CW_W        = $clog2(CW_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            slot_tick_i,
  input  logic            busy_i,
  input  logic            ds_det_i,
  input  logic            ds_match_i,
  input  logic            pending_i,
  input  logic            tx_done_i,
  input  logic            tx_ok_i,
  output logic            tx_start_o,
  output logic            ds_tx_o,
  output logic [CW_W-1:0] cw_o,
  output logic            prio_o
);
  localparam int              AIFS_W    = (AIFSN < 2) ? 1 : $clog2(AIFSN + 1);
  localparam logic [AIFS_W-1:0] AIFS_LAST = AIFS_W'(AIFSN - 1);

  edca_st_e          st_q, st_d;
  logic [CW_W-1:0]   bo_q, bo_d;
  logic [AIFS_W-1:0] aifs_q, aifs_d;
  logic              sent_q, sent_d;
  logic              tx_q, tx_d, ds_q, ds_d;
  logic              draw, res_vld, last, elig, in_wait;
  logic [CW_W-1:0]   rnd, cw;

  edca_lfsr #(.SEED(LFSR_SEED), .OUT_W(CW_W)) u_lfsr (
    .clk_i, .rst_ni, .step_i(draw), .value_o(rnd)
  );

  edca_cw_ctrl #(
    .CW_MIN(CW_MIN), .CW_MAX(CW_MAX), .RETRY_LIMIT(RETRY_LIMIT), .CW_W(CW_W)
  ) u_cw (
    .clk_i, .rst_ni, .done_i(res_vld), .ok_i(tx_ok_i),
    .cw_o(cw), .elig_o(elig), .last_o(last)
  );

  always_comb begin
    st_d    = st_q;
    bo_d    = bo_q;
    aifs_d  = aifs_q;
    sent_d  = sent_q;
    tx_d    = 1'b0;
    ds_d    = 1'b0;
    draw    = 1'b0;
    res_vld = 1'b0;
    unique case (st_q)
      ST_IDLE: if (pending_i) st_d = ST_DRAW;
      ST_DRAW: begin
        draw   = 1'b1;
        bo_d   = rnd & cw;
        aifs_d = '0;
        sent_d = 1'b0;
        st_d   = ST_AIFS;
      end
      ST_AIFS: if (slot_tick_i) begin
        if (busy_i) begin
          aifs_d = '0;
          sent_d = 1'b0;
        end else if (elig && !sent_q && aifs_q == '0) begin
          // own defer slot; same-BSS detection is the shared signal
          ds_d   = 1'b1;
          sent_d = 1'b1;
          if (ds_det_i && !ds_match_i) st_d = ST_LOCK;
        end else if (ds_det_i) begin
          aifs_d = '0;
          sent_d = 1'b0;
          st_d   = ST_LOCK;
        end else if (aifs_q == AIFS_LAST) begin
          aifs_d = '0;
          st_d   = ST_BACKOFF;
        end else begin
          aifs_d = aifs_q + 1'b1;
        end
      end
      ST_BACKOFF: if (slot_tick_i) begin
        if (busy_i) begin
          aifs_d = '0;
          sent_d = 1'b0;
          st_d   = ST_AIFS;
        end else if (ds_det_i) begin
          sent_d = 1'b0;
          st_d   = ST_LOCK;
        end else if (bo_q == '0) begin
          tx_d = 1'b1;
          st_d = ST_WAIT;
        end else begin
          bo_d = bo_q - 1'b1;
        end
      end
      ST_LOCK: if (slot_tick_i && busy_i) begin
        aifs_d = '0;
        sent_d = 1'b0;
        st_d   = ST_AIFS;
      end
      ST_WAIT: if (tx_done_i) begin
        res_vld = 1'b1;
        st_d    = (tx_ok_i || last) ? ST_IDLE : ST_DRAW;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bo_q   <= '0;
      aifs_q <= '0;
      sent_q <= 1'b0;
      tx_q   <= 1'b0;
      ds_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      bo_q   <= bo_d;
      aifs_q <= aifs_d;
      sent_q <= sent_d;
      tx_q   <= tx_d;
      ds_q   <= ds_d;
    end
  end

  assign in_wait    = (st_q == ST_WAIT);
  assign tx_start_o = tx_q;
  assign ds_tx_o    = ds_q;
  assign cw_o       = cw;
  assign prio_o     = elig;
endmodule

// File: rtl/edca_prio_chk.sv
module edca_prio_chk #(
  parameter int CW_MIN = 15,
  parameter int CW_MAX = 1023,
  parameter int CW_W   = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            slot_tick_i,
  input logic            busy_i,
  input logic            ds_det_i,
  input logic            tx_done_i,
  input logic            tx_ok_i,
  input logic            tx_start_o,
  input logic            ds_tx_o,
  input logic [CW_W-1:0] cw_o,
  input logic            prio_o,
  input logic            in_wait_i
);
  // R3
  tx_on_idle_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> ($past(slot_tick_i) && !$past(busy_i) && !$past(ds_det_i)));

  // R3
  tx_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  // R6
  ds_needs_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_tx_o |-> prio_o);

  // R6
  ds_tx_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ds_tx_o && tx_start_o));

  // R5
  cw_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cw_o) >= CW_MIN) && (int'(cw_o) <= CW_MAX));

  // R5
  fail_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !tx_ok_i && in_wait_i) |=>
      ((prio_o && cw_o >= $past(cw_o)) || (int'(cw_o) == CW_MIN && !prio_o)));

  // R10
  ok_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && tx_ok_i && in_wait_i) |=> (int'(cw_o) == CW_MIN && !prio_o));
endmodule

bind edca_prio_ctrl edca_prio_chk #(
  .CW_MIN(CW_MIN), .CW_MAX(CW_MAX), .CW_W(CW_W)
) u_chk (
  .clk_i, .rst_ni, .slot_tick_i, .busy_i, .ds_det_i, .tx_done_i, .tx_ok_i,
  .tx_start_o, .ds_tx_o, .cw_o, .prio_o, .in_wait_i(in_wait)
);

// File: tb/sim_edca_prio_ctrl.sv
module sim_edca_prio_ctrl;
  localparam int AIFSN  = 2;
  localparam int CW_MIN = 15;
  localparam int CW_MAX = 63;
  localparam int CW_W   = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic slot_tick_i = 0, busy_i = 0, ds_det_i = 0, ds_match_i = 0;
  logic pending_i = 0, tx_done_i = 0, tx_ok_i = 0;
  logic tx_start_o, ds_tx_o, prio_o;
  logic [CW_W-1:0] cw_o;

  int n_chk = 0, n_bad = 0;
  logic [15:0] lfsr_m = 16'hACE1;
  int cw_m = CW_MIN;
  int bo_m = 0;

  always #2 clk = ~clk;

  edca_prio_ctrl #(.AIFSN(AIFSN), .CW_MIN(CW_MIN), .CW_MAX(CW_MAX)) u0 (
    .clk_i(clk), .rst_ni, .slot_tick_i, .busy_i, .ds_det_i, .ds_match_i,
    .pending_i, .tx_done_i, .tx_ok_i, .tx_start_o, .ds_tx_o, .cw_o, .prio_o
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_draw();
    bo_m   = int'(lfsr_m) & cw_m;
    lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
  endtask

  function automatic int grow(input int c);
    return (c * 2 + 1 > CW_MAX) ? CW_MAX : c * 2 + 1;
  endfunction

  task automatic request();
    @(negedge clk) pending_i = 1'b1;
    @(negedge clk) pending_i = 1'b0;
    repeat (2) @(negedge clk);
    model_draw();
  endtask

  task automatic tick(input bit b, input bit d, input bit m, output bit tx, output bit ds);
    @(negedge clk);
    slot_tick_i = 1'b1; busy_i = b; ds_det_i = d; ds_match_i = m;
    @(negedge clk);
    slot_tick_i = 1'b0; busy_i = 1'b0; ds_det_i = 1'b0; ds_match_i = 1'b0;
    tx = tx_start_o; ds = ds_tx_o;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle_run(input int max, output int tx_at, output int ds_at);
    bit t, d;
    tx_at = 0; ds_at = 0;
    for (int i = 1; i <= max; i++) begin
      tick(1'b0, 1'b0, 1'b0, t, d);
      if (d && ds_at == 0) ds_at = i;
      if (t) begin tx_at = i; break; end
    end
  endtask

  // tx_done strobe; a non-final failure redraws two cycles later
  task automatic result(input bit ok);
    @(negedge clk) begin tx_done_i = 1'b1; tx_ok_i = ok; end
    @(negedge clk) begin tx_done_i = 1'b0; tx_ok_i = 1'b0; end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_start_o == 0 && ds_tx_o == 0, "R1", "pulses in reset", {tx_start_o, ds_tx_o}, 0);
    chk(int'(cw_o) == CW_MIN, "R1", "cw in reset", int'(cw_o), CW_MIN);
    chk(prio_o == 0, "R1", "prio in reset", prio_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_normal();
    int ta, da;
    request();
    idle_run(AIFSN + bo_m + 4, ta, da);
    chk(ta == AIFSN + bo_m + 1, "R3", "tx tick", ta, AIFSN + bo_m + 1);
    chk(da == 0, "R6", "ds without prio", da, 0);
    result(1'b1);
  endtask

  task automatic t_aifs_restart();
    int ta, da;
    bit t, d;
    request();
    tick(1'b0, 1'b0, 1'b0, t, d);
    tick(1'b1, 1'b0, 1'b0, t, d);
    chk(t == 0, "R2", "tx on busy tick", t, 0);
    idle_run(AIFSN + bo_m + 4, ta, da);
    chk(ta == AIFSN + bo_m + 1, "R2", "tx after restarted aifs", ta, AIFSN + bo_m + 1);
    result(1'b1);
  endtask

  task automatic t_freeze();
    int ta, da, k, seen;
    bit t, d;
    request();
    k = bo_m / 2;
    seen = 0;
    for (int i = 0; i < AIFSN + k; i++) begin
      tick(1'b0, 1'b0, 1'b0, t, d);
      seen |= int'(t);
    end
    tick(1'b1, 1'b0, 1'b0, t, d);
    seen |= int'(t);
    chk(seen == 0, "R4", "early tx before freeze", seen, 0);
    idle_run(AIFSN + bo_m + 4, ta, da);
    chk(ta == AIFSN + (bo_m - k) + 1, "R4", "tx after frozen resume", ta, AIFSN + (bo_m - k) + 1);
    result(1'b1);
  endtask

  task automatic t_prio_chain();
    int ta, da;
    bit t, d;
    request();
    idle_run(AIFSN + bo_m + 4, ta, da);
    chk(ta == AIFSN + bo_m + 1, "R3", "first attempt tx", ta, AIFSN + bo_m + 1);
    result(1'b0);
    cw_m = grow(cw_m);
    chk(int'(cw_o) == cw_m, "R5", "cw after 1st fail", int'(cw_o), cw_m);
    chk(prio_o == 1, "R5", "prio after fail", prio_o, 1);
    model_draw();
    idle_run(AIFSN + bo_m + 5, ta, da);
    chk(da == 1, "R6", "ds on first idle tick", da, 1);
    chk(ta == AIFSN + bo_m + 2, "R6", "prio tx tick", ta, AIFSN + bo_m + 2);
    // R7 same-BSS defer heard in own slot
    result(1'b0);
    cw_m = grow(cw_m);
    chk(int'(cw_o) == cw_m, "R5", "cw after 2nd fail", int'(cw_o), cw_m);
    model_draw();
    tick(1'b0, 1'b1, 1'b1, t, d);
    chk(d == 1, "R7", "ds sent with shared signal", d, 1);
    idle_run(AIFSN + bo_m + 4, ta, da);
    chk(ta == AIFSN + bo_m + 1, "R7", "tx after shared ds", ta, AIFSN + bo_m + 1);
    // R8 foreign-BSS defer heard in own slot
    result(1'b0);
    cw_m = grow(cw_m);
    chk(int'(cw_o) == CW_MAX, "R5", "cw capped", int'(cw_o), CW_MAX);
    model_draw();
    tick(1'b0, 1'b1, 1'b0, t, d);
    chk(d == 1, "R8", "ds sent before lockout", d, 1);
    idle_run(AIFSN + bo_m + 6, ta, da);
    chk(ta == 0, "R8", "tx during foreign lockout", ta, 0);
    tick(1'b1, 1'b0, 1'b0, t, d);
    idle_run(AIFSN + bo_m + 8, ta, da);
    chk(da == 1, "R8", "ds in next period", da, 1);
    chk(ta == AIFSN + bo_m + 2, "R8", "tx after lockout", ta, AIFSN + bo_m + 2);
    result(1'b1);
    cw_m = CW_MIN;
    chk(int'(cw_o) == CW_MIN, "R10", "cw after prio success", int'(cw_o), CW_MIN);
    chk(prio_o == 0, "R10", "prio cleared", prio_o, 0);
    idle_run(6, ta, da);
    chk(ta == 0 && da == 0, "R10", "idle without request", ta + da, 0);
  endtask

  task automatic t_nonelig_lock();
    int ta, da;
    bit t, d;
    request();
    tick(1'b0, 1'b1, 1'b1, t, d);
    chk(d == 0, "R9", "no ds when not eligible", d, 0);
    idle_run(AIFSN + bo_m + 6, ta, da);
    chk(ta == 0, "R9", "tx during lockout", ta, 0);
    tick(1'b1, 1'b0, 1'b0, t, d);
    idle_run(AIFSN + bo_m + 4, ta, da);
    chk(ta == AIFSN + bo_m + 1, "R9", "tx after lockout", ta, AIFSN + bo_m + 1);
    result(1'b1);
  endtask

  task automatic t_retry();
    int ta, da, exp_t;
    request();
    for (int a = 1; a <= 7; a++) begin
      idle_run(AIFSN + bo_m + 5, ta, da);
      exp_t = (a == 1) ? AIFSN + bo_m + 1 : AIFSN + bo_m + 2;
      chk(ta == exp_t, "R11", "tx of attempt", ta, exp_t);
      result(1'b0);
      if (a < 7) begin
        cw_m = grow(cw_m);
        chk(prio_o == 1 && int'(cw_o) == cw_m, "R11", "cw while retrying", int'(cw_o), cw_m);
        model_draw();
      end
    end
    cw_m = CW_MIN;
    chk(int'(cw_o) == CW_MIN, "R11", "cw after discard", int'(cw_o), CW_MIN);
    chk(prio_o == 0, "R11", "prio after discard", prio_o, 0);
    idle_run(20, ta, da);
    chk(ta == 0 && da == 0, "R11", "activity after discard", ta + da, 0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_aifs_restart();
    t_freeze();
    t_prio_chain();
    t_nonelig_lock();
    t_retry();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule